// File: doc/BRIEF.md
# Transport Stream PID Filter Router

This block sits after a transport-stream source and keeps only the packets that the system wants. It takes a byte stream of 188-byte transport packets. It finds and tracks the packet boundaries from the 0x47 sync byte and reads each packet's 13-bit PID. It then looks the PID up in a programmable table of 32 entries. A packet that matches an enabled entry is held whole in a buffer of ten packet slots. Each byte is tagged with the destination queue number that the winning entry names.

Each table entry carries two further options. With the strip option, a packet is delivered without its 4-byte header. With the split option, the adaptation-field bytes are tagged with a separate adaptation queue number. The rest of the packet keeps the entry's own queue. A downstream consumer drains the buffer over a valid/ready byte interface that carries packet start and end marks. Packets with the transport error bit set are thrown away and counted. A matched packet that arrives when all slots are taken is dropped whole, and a sticky overflow flag records the loss.

Top module: `tsf_router`

## Requirements
- R1: Lock is declared on the third of three sync bytes (0x47) found at exact 188-byte spacing. A candidate sequence may only begin on a byte that has `in_sop` high. Packets seen before lock are not stored. The packet whose sync byte completes the lock is processed.
- R2: While locked, a packet whose first byte is not 0x47 is not stored, and lock is kept. A second consecutive such miss drops lock, and `locked` goes low. After that, acquisition restarts under R1.
- R3: The PID is formed from byte 1 bits 4:0 (PID bits 12:8) and byte 2 (PID bits 7:0). A packet is stored only if an enabled table entry holds its PID. Packets that hit a disabled entry, or no entry at all, never appear at the output.
- R4: When several enabled entries hold the same PID, the entry with the lowest index decides the routing.
- R5: Every output byte of a stored packet carries, on `out_queue`, the queue number of the winning entry, unless R7 applies.
- R6: With strip clear, a packet is output as all 188 bytes, starting from the sync byte. With strip set, output starts at byte 4, so 184 bytes are delivered. `out_sop` marks the first byte delivered and `out_eop` marks byte 187.
- R7: With split set, a packet has an adaptation field when byte 3 bit 5 is 1. L is byte 4. For such a packet, the bytes at positions 4 through 4+L are tagged with the adaptation queue. That queue is the value on `cfg_af_queue` when the packet's last byte arrives. All other bytes keep the entry queue.
- R8: A packet with byte 1 bit 7 set is discarded whether its PID matches or not. Each such packet adds one to `err_count`, which saturates at its maximum.
- R9: The buffer holds at most 10 packets. Whether a slot is free is decided at the packet's sync byte. A matched, error-free packet that found no free slot is dropped whole, and it sets `overflow`, which stays set until reset.
- R10: A byte transfers when `out_valid` and `out_ready` are both high. Packets leave in arrival order, with their bytes in stream order. Outputs hold steady while `out_ready` is low.
- R11: After reset, `locked`, `overflow`, `err_count` and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | Source marks this byte as a packet start |
| in_data | input | 8 | Input stream byte |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 5 | Entry index written |
| cfg_en | input | 1 | Entry enable |
| cfg_pid | input | 13 | PID held by the entry |
| cfg_queue | input | 5 | Destination queue of the entry |
| cfg_strip | input | 1 | Deliver without the 4-byte header |
| cfg_split | input | 1 | Tag adaptation-field bytes separately |
| cfg_af_queue | input | 5 | Queue number for adaptation-field bytes |
| out_ready | input | 1 | Consumer accepts a byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_queue | output | 5 | Queue tag of the output byte |
| out_sop | output | 1 | First delivered byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| locked | output | 1 | Packet sync held |
| overflow | output | 1 | Sticky: a matched packet was lost to a full buffer |
| err_count | output | 8 | Saturating count of error-flagged packets |

## Verification
The bench builds the block with its default parameters: 32 table entries, 32 queues, ten slots and an 8-bit error counter. With these values, the lowest-index rule can be tested with entries 2 and 7, and the full-buffer drop appears after ten stalled packets. A garbage byte marked as a start forces the first lock attempt to fail. The bench also creates single misses, and double misses that cause relock. Stripped and split packets use adaptation lengths of 0, 10 and 183.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int unsigned TS_BYTES  = 188;
    localparam int unsigned HDR_BYTES = 4;
    localparam int unsigned PID_W     = 13;
    localparam logic [7:0]  SYNC_VAL  = 8'h47;

    typedef enum logic {
        SY_HUNT = 1'b0,
        SY_LOCK = 1'b1
    } sync_mode_t;
endpackage

// File: rtl/tsf_sync.sv
module tsf_sync
    import tsf_pkg::*;
#(
    parameter int unsigned PKT_BYTES  = TS_BYTES,
    parameter int unsigned LOCK_HITS  = 3,
    parameter int unsigned MISS_LIMIT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_sop,
    input  logic [7:0]                   in_data,
    output logic                         pkt_start,
    output logic [$clog2(PKT_BYTES)-1:0] byte_pos,
    output logic                         locked
);
    localparam int unsigned POS_W  = $clog2(PKT_BYTES);
    localparam int unsigned HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        sync_mode_t        mode;
        logic [POS_W-1:0]  pos;
        logic [HIT_W-1:0]  hits;
        logic [MISS_W-1:0] miss;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     tracking;
    logic     is_sync;

    always_comb begin
        st_d      = st_q;
        pkt_start = 1'b0;
        tracking  = (st_q.mode == SY_LOCK) || (st_q.hits != '0);
        is_sync   = (in_data == SYNC_VAL);
        if (in_valid) begin
            if (!tracking) begin
                if (in_sop && is_sync) begin
                    st_d.hits = HIT_W'(1);
                    st_d.pos  = POS_W'(1);
                end
            end else begin
                if (st_q.pos == '0) begin
                    if (st_q.mode == SY_HUNT) begin
                        if (is_sync) begin
                            if (st_q.hits == HIT_W'(LOCK_HITS - 1)) begin
                                st_d.mode = SY_LOCK;
                                st_d.miss = '0;
                                pkt_start = 1'b1;
                            end else begin
                                st_d.hits = st_q.hits + HIT_W'(1);
                            end
                        end else begin
                            st_d.hits = '0;
                        end
                    end else begin
                        if (is_sync) begin
                            st_d.miss = '0;
                            pkt_start = 1'b1;
                        end else if (st_q.miss == MISS_W'(MISS_LIMIT - 1)) begin
                            st_d.mode = SY_HUNT;
                            st_d.hits = '0;
                            st_d.miss = '0;
                        end else begin
                            st_d.miss = st_q.miss + MISS_W'(1);
                        end
                    end
                end
                st_d.pos = (st_q.pos == POS_W'(PKT_BYTES - 1)) ? '0 : st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SY_HUNT, pos: '0, hits: '0, miss: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_pos = st_q.pos;
    assign locked   = (st_q.mode == SY_LOCK);

    // R1
    lock_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_valid && in_data == SYNC_VAL));
endmodule

// File: rtl/tsf_pid_table.sv
module tsf_pid_table
    import tsf_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned Q_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic                       wr_valid,
    input  logic [PID_W-1:0]           wr_pid,
    input  logic [Q_W-1:0]             wr_queue,
    input  logic                       wr_strip,
    input  logic                       wr_split,
    input  logic [PID_W-1:0]           lk_pid,
    output logic                       lk_hit,
    output logic [Q_W-1:0]             lk_queue,
    output logic                       lk_strip,
    output logic                       lk_split
);
    typedef struct packed {
        logic             en;
        logic [PID_W-1:0] pid;
        logic [Q_W-1:0]   queue;
        logic             strip;
        logic             split;
    } entry_t;

    entry_t [ENTRIES-1:0] tab_d, tab_q;
    logic   [ENTRIES-1:0] match;
    entry_t               win;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tab_q[g].en && (tab_q[g].pid == lk_pid);
    end

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx] = '{en: wr_valid, pid: wr_pid, queue: wr_queue,
                              strip: wr_strip, split: wr_split};
        end
    end

    always_comb begin
        win = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) win = tab_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign lk_hit   = |match;
    assign lk_queue = win.queue;
    assign lk_strip = win.strip;
    assign lk_split = win.split;
endmodule

// File: rtl/tsf_pkt_buffer.sv
module tsf_pkt_buffer
    import tsf_pkg::*;
#(
    parameter int unsigned SLOTS     = 10,
    parameter int unsigned PKT_BYTES = TS_BYTES,
    parameter int unsigned Q_W       = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(PKT_BYTES)-1:0] wr_pos,
    input  logic [7:0]                   wr_data,
    input  logic                         commit,
    input  logic [Q_W-1:0]               c_queue,
    input  logic [Q_W-1:0]               c_afq,
    input  logic                         c_strip,
    input  logic                         c_afsplit,
    input  logic [7:0]                   c_aflen,
    output logic                         full,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [7:0]                   out_data,
    output logic [Q_W-1:0]               out_queue,
    output logic                         out_sop,
    output logic                         out_eop
);
    localparam int unsigned POS_W  = $clog2(PKT_BYTES);
    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
    localparam int unsigned ADDR_W = $clog2(SLOTS * PKT_BYTES);

    typedef struct packed {
        logic [Q_W-1:0] queue;
        logic [Q_W-1:0] afq;
        logic           strip;
        logic           afsplit;
        logic [7:0]     aflen;
    } meta_t;

    typedef struct packed {
        logic [SLOT_W-1:0] wr_ptr;
        logic [SLOT_W-1:0] rd_ptr;
        logic [CNT_W-1:0]  count;
        logic [POS_W-1:0]  k;
    } buf_st_t;

    logic [7:0]        mem    [SLOTS*PKT_BYTES];
    meta_t             meta_q [SLOTS];
    buf_st_t           st_d, st_q;
    meta_t             cur;
    logic [POS_W-1:0]  idx;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              in_af, pop, xfer;

    assign wr_addr = ADDR_W'(st_q.wr_ptr) * ADDR_W'(PKT_BYTES) + ADDR_W'(wr_pos);
    assign rd_addr = ADDR_W'(st_q.rd_ptr) * ADDR_W'(PKT_BYTES) + ADDR_W'(idx);

    always_comb begin
        cur       = meta_q[st_q.rd_ptr];
        idx       = st_q.k + (cur.strip ? POS_W'(HDR_BYTES) : '0);
        out_valid = (st_q.count != '0);
        out_sop   = (st_q.k == '0);
        out_eop   = (idx == POS_W'(PKT_BYTES - 1));
        in_af     = cur.afsplit && (idx >= POS_W'(HDR_BYTES))
                    && ({1'b0, idx} <= (9'(HDR_BYTES) + {1'b0, cur.aflen}));
        out_queue = in_af ? cur.afq : cur.queue;
        out_data  = mem[rd_addr];
        xfer      = out_valid && out_ready;
        pop       = xfer && out_eop;

        st_d = st_q;
        if (xfer) begin
            if (out_eop) begin
                st_d.k      = '0;
                st_d.rd_ptr = (st_q.rd_ptr == SLOT_W'(SLOTS - 1)) ? '0 : st_q.rd_ptr + SLOT_W'(1);
            end else begin
                st_d.k = st_q.k + POS_W'(1);
            end
        end
        if (commit) begin
            st_d.wr_ptr = (st_q.wr_ptr == SLOT_W'(SLOTS - 1)) ? '0 : st_q.wr_ptr + SLOT_W'(1);
        end
        st_d.count = st_q.count + CNT_W'(commit) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (commit) begin
            meta_q[st_q.wr_ptr] <= '{queue: c_queue, afq: c_afq, strip: c_strip,
                                    afsplit: c_afsplit, aflen: c_aflen};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = (st_q.count == CNT_W'(SLOTS));

    // R9
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(SLOTS));
    // R9
    commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full);
    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_queue) && $stable(out_sop)));
endmodule

// File: rtl/tsf_router.sv
module tsf_router
    import tsf_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 32,
    parameter int unsigned N_QUEUES  = 32,
    parameter int unsigned N_SLOTS   = 10,
    parameter int unsigned ERR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic [7:0]                    in_data,
    input  logic                          cfg_we,
    input  logic [$clog2(N_ENTRIES)-1:0]  cfg_idx,
    input  logic                          cfg_en,
    input  logic [12:0]                   cfg_pid,
    input  logic [$clog2(N_QUEUES)-1:0]   cfg_queue,
    input  logic                          cfg_strip,
    input  logic                          cfg_split,
    input  logic [$clog2(N_QUEUES)-1:0]   cfg_af_queue,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [7:0]                    out_data,
    output logic [$clog2(N_QUEUES)-1:0]   out_queue,
    output logic                          out_sop,
    output logic                          out_eop,
    output logic                          locked,
    output logic                          overflow,
    output logic [ERR_W-1:0]              err_count
);
    localparam int unsigned Q_W   = $clog2(N_QUEUES);
    localparam int unsigned POS_W = $clog2(TS_BYTES);

    typedef struct packed {
        logic             cap;
        logic             drop;
        logic             tei;
        logic [PID_W-1:0] pid;
        logic             has_af;
        logic [7:0]       aflen;
        logic             ovf;
        logic [ERR_W-1:0] err;
    } cap_st_t;

    cap_st_t          st_d, st_q;
    logic             pkt_start, buf_full, cap_now, drop_now, wr_en, commit;
    logic [POS_W-1:0] pos;
    logic             hit, e_strip, e_split;
    logic [Q_W-1:0]   e_queue;

    tsf_sync #(.PKT_BYTES(TS_BYTES), .LOCK_HITS(3), .MISS_LIMIT(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .pkt_start(pkt_start), .byte_pos(pos), .locked(locked)
    );

    tsf_pid_table #(.ENTRIES(N_ENTRIES), .Q_W(Q_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
        .wr_valid(cfg_en), .wr_pid(cfg_pid), .wr_queue(cfg_queue),
        .wr_strip(cfg_strip), .wr_split(cfg_split), .lk_pid(st_q.pid),
        .lk_hit(hit), .lk_queue(e_queue), .lk_strip(e_strip), .lk_split(e_split)
    );

    tsf_pkt_buffer #(.SLOTS(N_SLOTS), .PKT_BYTES(TS_BYTES), .Q_W(Q_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pos(pos), .wr_data(in_data),
        .commit(commit), .c_queue(e_queue), .c_afq(cfg_af_queue), .c_strip(e_strip),
        .c_afsplit(e_split && st_q.has_af), .c_aflen(st_q.aflen), .full(buf_full),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_queue(out_queue), .out_sop(out_sop), .out_eop(out_eop)
    );

    always_comb begin
        st_d     = st_q;
        commit   = 1'b0;
        cap_now  = in_valid && (pkt_start || st_q.cap);
        drop_now = pkt_start ? buf_full : st_q.drop;
        wr_en    = cap_now && !drop_now;
        if (pkt_start) begin
            st_d.cap    = 1'b1;
            st_d.drop   = buf_full;
            st_d.tei    = 1'b0;
            st_d.has_af = 1'b0;
            st_d.aflen  = '0;
        end
        if (cap_now) begin
            if (pos == POS_W'(1)) begin
                st_d.tei         = in_data[7];
                st_d.pid[12:8]   = in_data[4:0];
            end else if (pos == POS_W'(2)) begin
                st_d.pid[7:0]    = in_data;
            end else if (pos == POS_W'(3)) begin
                st_d.has_af      = in_data[5];
            end else if (pos == POS_W'(4)) begin
                st_d.aflen       = in_data;
            end else if (pos == POS_W'(TS_BYTES - 1)) begin
                st_d.cap = 1'b0;
                if (st_q.tei) begin
                    if (st_q.err != '1) st_d.err = st_q.err + ERR_W'(1);
                end else if (hit) begin
                    if (drop_now) st_d.ovf = 1'b1;
                    else          commit   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow  = st_q.ovf;
    assign err_count = st_q.err;

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R8
    err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_count >= $past(err_count));
endmodule

// File: tb/tsf_router_test.sv
module tsf_router_test;
    localparam int PKT   = 188;
    localparam int SLOTS = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0] in_data = '0;
    logic       cfg_we = 1'b0, cfg_en = 1'b0, cfg_strip = 1'b0, cfg_split = 1'b0;
    logic [4:0] cfg_idx = '0, cfg_queue = '0, cfg_af_queue = 5'd31;
    logic [12:0] cfg_pid = '0;
    logic       out_ready = 1'b0;
    logic       out_valid, out_sop, out_eop, locked, overflow;
    logic [7:0] out_data, err_count;
    logic [4:0] out_queue;

    tsf_router uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_pid(cfg_pid),
        .cfg_queue(cfg_queue), .cfg_strip(cfg_strip), .cfg_split(cfg_split),
        .cfg_af_queue(cfg_af_queue), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_queue(out_queue), .out_sop(out_sop), .out_eop(out_eop),
        .locked(locked), .overflow(overflow), .err_count(err_count)
    );

    typedef struct {
        logic [7:0] d;
        logic [4:0] q;
        logic       sop;
        logic       eop;
        string      tag;
    } ob_t;

    ob_t        exp_q[$];
    bit         m_en[32];
    logic [12:0] m_pid[32];
    logic [4:0] m_qn[32];
    bit         m_strip[32], m_split[32];
    logic [7:0] m_pkt[PKT];
    int  m_hits, m_miss, m_pos, m_slots, m_err;
    bit  m_locked, m_track, m_cap, m_drop, m_ovf, do_pop, full_b;
    string phase = "R11", m_tag = "R11";
    int  compared = 0, mismatched = 0, ready_mode = 1, rcnt = 0;
    bit  running = 0, done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void finish_pkt();
        logic [12:0] pid;
        int win;
        int st;
        win = -1;
        pid = {m_pkt[1][4:0], m_pkt[2]};
        if (m_pkt[1][7]) begin
            if (m_err < 255) m_err++;
            return;
        end
        for (int i = 0; i < 32; i++) if (win < 0 && m_en[i] && m_pid[i] == pid) win = i;
        if (win < 0) return;
        if (m_drop) begin m_ovf = 1; return; end
        st = m_strip[win] ? 4 : 0;
        for (int i = st; i < PKT; i++) begin
            ob_t b;
            bit af;
            af = m_split[win] && m_pkt[3][5] && i >= 4 && i <= 4 + int'(m_pkt[4]);
            b.d = m_pkt[i]; b.q = af ? cfg_af_queue : m_qn[win];
            b.sop = (i == st); b.eop = (i == PKT - 1); b.tag = m_tag;
            exp_q.push_back(b);
        end
        m_slots++;
    endfunction

    function automatic void model_byte(logic [7:0] d, logic sop, bit full);
        bit start;
        start = 0;
        if (!m_track) begin
            if (sop && d == 8'h47) begin m_track = 1; m_hits = 1; m_pos = 1; end
            return;
        end
        if (m_pos == 0) begin
            if (!m_locked) begin
                if (d == 8'h47) begin
                    m_hits++;
                    if (m_hits == 3) begin m_locked = 1; m_miss = 0; start = 1; end
                end else begin m_hits = 0; m_track = 0; end
            end else begin
                if (d == 8'h47) begin m_miss = 0; start = 1; end
                else begin
                    m_miss++;
                    if (m_miss == 2) begin m_locked = 0; m_track = 0; m_hits = 0; m_miss = 0; end
                end
            end
        end
        if (start) begin m_cap = 1; m_drop = full; m_tag = phase; end
        if (m_cap) m_pkt[m_pos] = d;
        if (m_cap && m_pos == PKT - 1) begin finish_pkt(); m_cap = 0; end
        m_pos = (m_pos + 1) % PKT;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_hits = 0; m_miss = 0; m_pos = 0; m_slots = 0; m_err = 0;
            m_locked = 0; m_track = 0; m_cap = 0; m_drop = 0; m_ovf = 0;
            for (int i = 0; i < 32; i++) begin
                m_en[i] = 0; m_pid[i] = '0; m_qn[i] = '0; m_strip[i] = 0; m_split[i] = 0;
            end
        end else begin
            do_pop = (exp_q.size() > 0) && out_ready;
            full_b = (m_slots == SLOTS);
            if (in_valid) model_byte(in_data, in_sop, full_b);
            if (cfg_we) begin
                m_en[cfg_idx] = cfg_en; m_pid[cfg_idx] = cfg_pid; m_qn[cfg_idx] = cfg_queue;
                m_strip[cfg_idx] = cfg_strip; m_split[cfg_idx] = cfg_split;
            end
            if (do_pop) begin
                ob_t b;
                b = exp_q.pop_front();
                if (b.eop) m_slots--;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            string t;
            t = (exp_q.size() > 0) ? exp_q[0].tag : phase;
            chk(phase, "locked R1 R2", int'(locked), int'(m_locked));
            chk(phase, "overflow R9", int'(overflow), int'(m_ovf));
            chk(phase, "err_count R8", int'(err_count), m_err);
            chk(t, "out_valid R10", int'(out_valid), int'(exp_q.size() > 0));
            if (out_valid && exp_q.size() > 0) begin
                chk(t, "out_data R10", int'(out_data), int'(exp_q[0].d));
                chk(t, "out_queue R5 R7", int'(out_queue), int'(exp_q[0].q));
                chk(t, "out_sop R6", int'(out_sop), int'(exp_q[0].sop));
                chk(t, "out_eop R6", int'(out_eop), int'(exp_q[0].eop));
            end
        end
    end

    always @(negedge clk) begin
        rcnt++;
        case (ready_mode)
            0:       out_ready <= 1'b1;
            2:       out_ready <= 1'b0;
            default: out_ready <= (rcnt % 3) != 0;
        endcase
    end

    task automatic put(logic [7:0] d, logic sop);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = sop;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0;
        end
    endtask

    task automatic cfg(int idx, bit en, logic [12:0] pid, logic [4:0] q, bit strip, bit split);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_en = en; cfg_pid = pid;
        cfg_queue = q; cfg_strip = strip; cfg_split = split;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_pkt(string tag, logic [12:0] pid, bit tei, logic [1:0] afc,
                            logic [7:0] aflen, bit good);
        phase = tag;
        for (int i = 0; i < PKT; i++) begin
            logic [7:0] b;
            if (i == 0)      b = good ? 8'h47 : 8'hB8;
            else if (i == 1) b = {tei, 2'b00, pid[12:8]};
            else if (i == 2) b = pid[7:0];
            else if (i == 3) b = {2'b00, afc, 4'(i)};
            else if (i == 4) b = afc[1] ? aflen : 8'(pid[3:0] + 4'd9);
            else             b = 8'(i * 7) ^ pid[7:0];
            put(b, i == 0);
            if (i % 61 == 60) idle(1);
        end
        idle(1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R11", "locked at reset", int'(locked), 0);
        chk("R11", "overflow at reset", int'(overflow), 0);
        chk("R11", "err_count at reset", int'(err_count), 0);
        chk("R11", "out_valid at reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;
        phase = "R3";
        cfg(0, 0, 13'h0200, 5'd1, 0, 0);
        cfg(2, 1, 13'h0300, 5'd7, 0, 0);
        cfg(7, 1, 13'h0300, 5'd9, 1, 0);
        cfg(5, 1, 13'h0100, 5'd3, 0, 0);
        cfg(10, 1, 13'h0ABC, 5'd12, 1, 0);
        cfg(20, 1, 13'h1234, 5'd20, 0, 1);
        cfg(31, 1, 13'h1FFE, 5'd30, 1, 1);
        // R1: stray start byte makes the first candidate fail
        phase = "R1";
        put(8'h47, 1'b1); put(8'h12, 1'b0); put(8'h34, 1'b0); idle(2);
        for (int n = 0; n < 5; n++) send_pkt("R1", 13'h0100, 0, 2'b01, 8'd0, 1);
        send_pkt("R3", 13'h0200, 0, 2'b01, 8'd0, 1);
        send_pkt("R3", 13'h0555, 0, 2'b01, 8'd0, 1);
        send_pkt("R5", 13'h0100, 0, 2'b01, 8'd0, 1);
        send_pkt("R4", 13'h0300, 0, 2'b01, 8'd0, 1);
        send_pkt("R6", 13'h0ABC, 0, 2'b01, 8'd0, 1);
        send_pkt("R7", 13'h1234, 0, 2'b11, 8'd10, 1);
        send_pkt("R7", 13'h1234, 0, 2'b10, 8'd183, 1);
        send_pkt("R7", 13'h1234, 0, 2'b01, 8'd0, 1);
        send_pkt("R7", 13'h1FFE, 0, 2'b11, 8'd0, 1);
        send_pkt("R8", 13'h0100, 1, 2'b01, 8'd0, 1);
        send_pkt("R8", 13'h0555, 1, 2'b01, 8'd0, 1);
        idle(3000);
        phase = "R9";
        ready_mode = 2;
        for (int n = 0; n < 12; n++) send_pkt("R9", 13'h0100, 0, 2'b01, 8'd0, 1);
        ready_mode = 0;
        idle(2500);
        ready_mode = 1;
        send_pkt("R2", 13'h0100, 0, 2'b01, 8'd0, 0);
        send_pkt("R2", 13'h0100, 0, 2'b01, 8'd0, 1);
        send_pkt("R2", 13'h0100, 0, 2'b01, 8'd0, 0);
        send_pkt("R2", 13'h0100, 0, 2'b01, 8'd0, 0);
        for (int n = 0; n < 4; n++) send_pkt("R2", 13'h0100, 0, 2'b01, 8'd0, 1);
        idle(3000);
        phase = "R10";
        chk("R8", "final error total", int'(err_count), 2);
        chk("R9", "overflow still set", int'(overflow), 1);
        chk("R10", "buffer drained", int'(out_valid), 0);
        chk("R2", "relocked", int'(locked), 1);
        running = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule